// File: doc/BRIEF.md
# Interrupt Controller Command Word Decoder

This block sits on the processor write path of an eight-input interrupt controller. It sorts each write into either the initialization sequence or one of the three operation command words. From the sorted writes it keeps the controller's configuration: trigger style, vector interval, single or cascaded use, the optional fourth initialization word's mode bits, the vector base, the cascade slave byte, the channel mask and the special-mask flag.

An initialization word with A0 low and data bit 4 set starts the sequence again from any state. The writes with A0 high that follow are taken in order as the vector base, then the cascade word (only when the single flag is clear), then the mode word (only when the fourth-word-needed flag is set). After the last expected word the block enters run mode. In run mode an A0-high write loads the mask. A0-low writes are told apart by data bits 4 and 3, and the rotate/end-of-interrupt command or the poll/read command is passed on as a one-cycle strobe with held fields. Priority resolution and register read-back belong to other blocks.

Top module: `cmd_word_seq`

## Requirements
- R1: After reset every output is zero and `init_done` is low. A0=1 writes before the first initialization word leave `mask` and `vec_base` at zero.
- R2: A write with A0=0 and D4=1 restarts the sequence from any state, including mid-sequence and run mode. It latches D3 into `level_trig`, D2 into `intv4`, D1 into `single` and D0 into `need_icw4`. It clears `mask`, `spec_mask`, `slave_cfg` and all fourth-word mode outputs, drops `init_done`, and raises `init_clr` for exactly one cycle.
- R3: After the restart, the next A0=1 write loads `vec_base`. When `single`=0 the following A0=1 write loads `slave_cfg`. When `need_icw4`=1 the next A0=1 write loads the mode word. `init_done` rises with the last expected word.
- R4: When `need_icw4`=0 the mode word is skipped and `sfnm`, `buf_mode`, `buf_master`, `aeoi` and `cpu86` all read zero.
- R5: The mode word maps D4 to `sfnm`, D3 to `buf_mode`, D1 to `aeoi` and D0 to `cpu86`. `buf_master` equals D2 only when D3=1 and is zero when D3=0.
- R6: While `init_done` is low, A0=1 writes are taken as initialization words and never change `mask`. A0=0 writes with D4=0 are ignored: they give no strobe and change no state.
- R7: In run mode an A0=1 write loads `mask` with the data byte. Bit n set means channel n is inhibited.
- R8: In run mode an A0=0 write with D4..D3=00 pulses `ocw2_stb` for one cycle. It loads `rot`=D7, `sel`=D6, `eoi`=D5 and `lvl`=D2..D0, and these fields hold until the next such write.
- R9: In run mode an A0=0 write with D4..D3=01 pulses `ocw3_stb` for one cycle. It loads `poll`=D2, `rd_reg`=D1 and `rd_is`=D0.
- R10: In such a write, D6=1 sets `spec_mask` to D5. With D6=0, D5 has no effect on `spec_mask`.
- R11: All outputs change on the clock edge that samples the write. The strobes are low on every cycle that does not follow an accepted command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| a0 | input | 1 | Address bit selecting the command word group |
| wr_data | input | 8 | Written data byte |
| init_done | output | 1 | Initialization sequence complete |
| init_clr | output | 1 | One-cycle pulse on restart, clears in-service state |
| level_trig | output | 1 | Level triggering selected |
| intv4 | output | 1 | Four-byte vector interval |
| single | output | 1 | Single controller, no cascade word |
| need_icw4 | output | 1 | Mode word expected |
| vec_base | output | 8 | Vector base byte |
| slave_cfg | output | 8 | Cascade slave byte |
| sfnm | output | 1 | Special fully nested mode |
| buf_mode | output | 1 | Buffered mode |
| buf_master | output | 1 | Master when buffered |
| aeoi | output | 1 | Automatic end of interrupt |
| cpu86 | output | 1 | 16-bit processor vectoring |
| mask | output | 8 | Channel mask |
| spec_mask | output | 1 | Special mask mode |
| ocw2_stb | output | 1 | Rotate/EOI command pulse |
| rot | output | 1 | Rotate bit |
| sel | output | 1 | Specific level bit |
| eoi | output | 1 | End-of-interrupt bit |
| lvl | output | 3 | Level field |
| ocw3_stb | output | 1 | Poll/read command pulse |
| poll | output | 1 | Poll request |
| rd_reg | output | 1 | Read register request |
| rd_is | output | 1 | In-service select for read |

## Verification
The hardest states to reach are the paths that depend on earlier writes: a restart that lands in the middle of the cascade or mode step, and the mode word being skipped after an earlier sequence had set its bits. The bench first runs a full four-word sequence so that every mode bit is one. It then restarts with the single flag set and the fourth-word flag clear, and checks that the mode bits drop to zero. It also restarts between the vector and cascade words and checks that the next A0-high write goes to the vector base again. Lookalike operation words sent during initialization confirm that nothing leaks into the mask or the strobes.

// File: rtl/cws_pkg.sv
package cws_pkg;
   typedef enum logic [2:0] {
      ST_WAIT = 3'd0,
      ST_ICW2 = 3'd1,
      ST_ICW3 = 3'd2,
      ST_ICW4 = 3'd3,
      ST_RUN  = 3'd4
   } seq_st_t;

   // mode word fields, packed in data-bit order D4..D0
   typedef struct packed {
      logic sfnm;
      logic bufm;
      logic ms;
      logic aeoi;
      logic cpu86;
   } mode_t;
endpackage

// File: rtl/cws_seq.sv
module cws_seq
   import cws_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic          a0,
   input  logic [DW-1:0] wr_data,
   output logic          icw1_hit,
   output logic          ocw1_hit,
   output logic          ocw2_hit,
   output logic          ocw3_hit,
   output logic          init_done,
   output logic          level_trig,
   output logic          intv4,
   output logic          single,
   output logic          need_icw4,
   output logic [DW-1:0] vec_base,
   output logic [DW-1:0] slave_cfg,
   output mode_t         mode
);
   seq_st_t st_q, st_d;
   logic    hi_wr, in_init;

   assign hi_wr    = wr_en & a0;
   assign in_init  = (st_q == ST_ICW2) | (st_q == ST_ICW3) | (st_q == ST_ICW4);
   assign icw1_hit = wr_en & ~a0 & wr_data[4];
   assign ocw1_hit = hi_wr & (st_q == ST_RUN);
   assign ocw2_hit = wr_en & ~a0 & ~wr_data[4] & ~wr_data[3] & (st_q == ST_RUN);
   assign ocw3_hit = wr_en & ~a0 & ~wr_data[4] &  wr_data[3] & (st_q == ST_RUN);

   always_comb begin
      st_d = st_q;
      if (icw1_hit) begin
         st_d = ST_ICW2;
      end else if (hi_wr) begin
         unique case (st_q)
            ST_ICW2: st_d = !single ? ST_ICW3 : (need_icw4 ? ST_ICW4 : ST_RUN);
            ST_ICW3: st_d = need_icw4 ? ST_ICW4 : ST_RUN;
            ST_ICW4: st_d = ST_RUN;
            default: st_d = st_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_WAIT;
         level_trig <= 1'b0;
         intv4      <= 1'b0;
         single     <= 1'b0;
         need_icw4  <= 1'b0;
         vec_base   <= '0;
         slave_cfg  <= '0;
         mode       <= '0;
      end else begin
         st_q <= st_d;
         if (icw1_hit) begin
            level_trig <= wr_data[3];
            intv4      <= wr_data[2];
            single     <= wr_data[1];
            need_icw4  <= wr_data[0];
            slave_cfg  <= '0;
            mode       <= '0;
         end else if (hi_wr && in_init) begin
            case (st_q)
               ST_ICW2: vec_base  <= wr_data;
               ST_ICW3: slave_cfg <= wr_data;
               ST_ICW4: mode      <= mode_t'(wr_data[4:0]);
               default: ;
            endcase
         end
      end
   end

   assign init_done = (st_q == ST_RUN);

   AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      icw1_hit |=> (st_q == ST_ICW2) && !init_done); // R2
   AST_SKIP_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_wr && st_q == ST_ICW2 && single && !need_icw4) |=> (mode == '0) && init_done); // R4
   AST_CASCADE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_wr && st_q == ST_ICW2 && !single) |=> (st_q == ST_ICW3)); // R3
   AST_INIT_NO_OCW: assert property (@(posedge clk) disable iff (!rst_n)
      !init_done |-> !(ocw1_hit || ocw2_hit || ocw3_hit)); // R6
endmodule

// File: rtl/cws_opreg.sv
module cws_opreg #(
   parameter int N_IN          = 8,
   parameter bit CLR_ON_INIT   = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            icw1_hit,
   input  logic            ocw1_hit,
   input  logic            ocw3_hit,
   input  logic [7:0]      wr_data,
   output logic [N_IN-1:0] mask,
   output logic            spec_mask
);
   generate
      for (genvar i = 0; i < N_IN; i++) begin : g_mbit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                      mask[i] <= 1'b0;
            else if (icw1_hit && CLR_ON_INIT) mask[i] <= 1'b0;
            else if (ocw1_hit)               mask[i] <= wr_data[i];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      spec_mask <= 1'b0;
      else if (icw1_hit)               spec_mask <= 1'b0;
      else if (ocw3_hit && wr_data[6]) spec_mask <= wr_data[5];
   end

   generate
      if (CLR_ON_INIT) begin : g_clr_chk
         AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
            icw1_hit |=> (mask == '0) && !spec_mask); // R2
      end
   endgenerate

   AST_SMM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (ocw3_hit && !wr_data[6]) |=> $stable(spec_mask)); // R10
   AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (ocw1_hit && !icw1_hit) |=> (mask == $past(wr_data[N_IN-1:0]))); // R7
endmodule

// File: rtl/cws_cmdout.sv
module cws_cmdout #(
   parameter int LVL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             icw1_hit,
   input  logic             ocw2_hit,
   input  logic             ocw3_hit,
   input  logic [7:0]       wr_data,
   output logic             init_clr,
   output logic             ocw2_stb,
   output logic             rot,
   output logic             sel,
   output logic             eoi,
   output logic [LVL_W-1:0] lvl,
   output logic             ocw3_stb,
   output logic             poll,
   output logic             rd_reg,
   output logic             rd_is
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         init_clr <= 1'b0;
         ocw2_stb <= 1'b0;
         ocw3_stb <= 1'b0;
      end else begin
         init_clr <= icw1_hit;
         ocw2_stb <= ocw2_hit;
         ocw3_stb <= ocw3_hit;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rot <= 1'b0;
         sel <= 1'b0;
         eoi <= 1'b0;
         lvl <= '0;
      end else if (ocw2_hit) begin
         rot <= wr_data[7];
         sel <= wr_data[6];
         eoi <= wr_data[5];
         lvl <= wr_data[LVL_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         poll   <= 1'b0;
         rd_reg <= 1'b0;
         rd_is  <= 1'b0;
      end else if (ocw3_hit) begin
         poll   <= wr_data[2];
         rd_reg <= wr_data[1];
         rd_is  <= wr_data[0];
      end
   end

   AST_STB_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({init_clr, ocw2_stb, ocw3_stb})); // R11
   AST_OCW2_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (ocw2_stb && !ocw2_hit) |=> !ocw2_stb); // R8
   AST_OCW3_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (ocw3_stb && !ocw3_hit) |=> !ocw3_stb); // R9
   AST_OCW2_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !ocw2_hit |=> $stable({rot, sel, eoi, lvl})); // R8
endmodule

// File: rtl/cmd_word_seq.sv
module cmd_word_seq
   import cws_pkg::*;
#(
   parameter int DW          = 8,
   parameter int N_IN        = 8,
   parameter bit CLR_ON_INIT = 1'b1,
   localparam int LVL_W      = $clog2(N_IN)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             a0,
   input  logic [DW-1:0]    wr_data,
   output logic             init_done,
   output logic             init_clr,
   output logic             level_trig,
   output logic             intv4,
   output logic             single,
   output logic             need_icw4,
   output logic [DW-1:0]    vec_base,
   output logic [DW-1:0]    slave_cfg,
   output logic             sfnm,
   output logic             buf_mode,
   output logic             buf_master,
   output logic             aeoi,
   output logic             cpu86,
   output logic [N_IN-1:0]  mask,
   output logic             spec_mask,
   output logic             ocw2_stb,
   output logic             rot,
   output logic             sel,
   output logic             eoi,
   output logic [LVL_W-1:0] lvl,
   output logic             ocw3_stb,
   output logic             poll,
   output logic             rd_reg,
   output logic             rd_is
);
   generate
      if (DW != 8) begin : g_bad_dw
         $error("cmd_word_seq: command words are 8 bits wide");
      end
      if (N_IN != 8) begin : g_bad_nin
         $error("cmd_word_seq: exactly 8 request inputs supported");
      end
   endgenerate

   logic  icw1_hit, ocw1_hit, ocw2_hit, ocw3_hit;
   mode_t mode;

   cws_seq #(.DW(DW)) u_seq (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .a0(a0), .wr_data(wr_data),
      .icw1_hit(icw1_hit), .ocw1_hit(ocw1_hit), .ocw2_hit(ocw2_hit), .ocw3_hit(ocw3_hit),
      .init_done(init_done), .level_trig(level_trig), .intv4(intv4), .single(single),
      .need_icw4(need_icw4), .vec_base(vec_base), .slave_cfg(slave_cfg), .mode(mode)
   );

   cws_opreg #(.N_IN(N_IN), .CLR_ON_INIT(CLR_ON_INIT)) u_opreg (
      .clk(clk), .rst_n(rst_n), .icw1_hit(icw1_hit), .ocw1_hit(ocw1_hit),
      .ocw3_hit(ocw3_hit), .wr_data(wr_data), .mask(mask), .spec_mask(spec_mask)
   );

   cws_cmdout #(.LVL_W(LVL_W)) u_cmd (
      .clk(clk), .rst_n(rst_n), .icw1_hit(icw1_hit), .ocw2_hit(ocw2_hit),
      .ocw3_hit(ocw3_hit), .wr_data(wr_data), .init_clr(init_clr),
      .ocw2_stb(ocw2_stb), .rot(rot), .sel(sel), .eoi(eoi), .lvl(lvl),
      .ocw3_stb(ocw3_stb), .poll(poll), .rd_reg(rd_reg), .rd_is(rd_is)
   );

   assign sfnm       = mode.sfnm;
   assign buf_mode   = mode.bufm;
   assign buf_master = mode.bufm & mode.ms;
   assign aeoi       = mode.aeoi;
   assign cpu86      = mode.cpu86;

   AST_BUF_SLAVE: assert property (@(posedge clk) disable iff (!rst_n)
      !buf_mode |-> !buf_master); // R5
   AST_INIT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      init_clr |-> !init_done); // R2
endmodule

// File: tb/sim_cmd_word_seq.sv
module sim_cmd_word_seq;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic       a0 = 1'b0;
   logic [7:0] wr_data = '0;
   logic       init_done, init_clr, level_trig, intv4, single, need_icw4;
   logic [7:0] vec_base, slave_cfg, mask;
   logic       sfnm, buf_mode, buf_master, aeoi, cpu86, spec_mask;
   logic       ocw2_stb, rot, sel, eoi, ocw3_stb, poll, rd_reg, rd_is;
   logic [2:0] lvl;

   int n_vec = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cmd_word_seq u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .a0(a0), .wr_data(wr_data),
      .init_done(init_done), .init_clr(init_clr), .level_trig(level_trig),
      .intv4(intv4), .single(single), .need_icw4(need_icw4), .vec_base(vec_base),
      .slave_cfg(slave_cfg), .sfnm(sfnm), .buf_mode(buf_mode), .buf_master(buf_master),
      .aeoi(aeoi), .cpu86(cpu86), .mask(mask), .spec_mask(spec_mask),
      .ocw2_stb(ocw2_stb), .rot(rot), .sel(sel), .eoi(eoi), .lvl(lvl),
      .ocw3_stb(ocw3_stb), .poll(poll), .rd_reg(rd_reg), .rd_is(rd_is)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // drive one write; returns at the negedge after the sampling edge
   task automatic wr(input logic ad, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; a0 = ad; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; a0 = 1'b0; wr_data = '0;
   endtask

   task automatic idle();
      @(negedge clk);
   endtask

   function automatic logic [4:0] modev();
      return {sfnm, buf_mode, buf_master, aeoi, cpu86};
   endfunction

   task automatic t_reset();
      chk("R1 init_done", init_done, 0);
      chk("R1 mask", mask, 0);
      chk("R1 cfg", {level_trig, intv4, single, need_icw4, modev()}, 0);
      chk("R1 strobes", {init_clr, ocw2_stb, ocw3_stb}, 0);
      wr(1'b1, 8'h55);
      chk("R1 pre-init mask", mask, 0);
      chk("R1 pre-init vec", vec_base, 0);
   endtask

   task automatic t_full_seq();
      wr(1'b0, 8'h1D);                       // LTIM ADI IC4, cascade
      chk("R2 init_clr pulse", init_clr, 1);
      chk("R2 icw1 fields", {level_trig, intv4, single, need_icw4}, 4'b1101);
      chk("R2 not done", init_done, 0);
      idle();
      chk("R2 init_clr one cycle", init_clr, 0);
      wr(1'b1, 8'h40);
      chk("R3 vec_base", vec_base, 8'h40);
      chk("R6 mask untouched", mask, 0);
      chk("R3 not done after vec", init_done, 0);
      wr(1'b0, 8'h6B);                       // looks like a read cmd
      chk("R6 no strobe in init", {ocw2_stb, ocw3_stb}, 0);
      chk("R6 spec_mask untouched", spec_mask, 0);
      wr(1'b1, 8'h04);
      chk("R3 slave_cfg", slave_cfg, 8'h04);
      chk("R3 not done before mode", init_done, 0);
      wr(1'b1, 8'h1F);
      chk("R5 mode all set", modev(), 5'b11111);
      chk("R3 done", init_done, 1);
      chk("R6 mask after init", mask, 0);
   endtask

   task automatic t_skip_mode();
      wr(1'b1, 8'hA5);
      chk("R7 mask load", mask, 8'hA5);
      wr(1'b0, 8'h68);
      chk("R10 spec set", spec_mask, 1);
      wr(1'b0, 8'h12);                       // single, no mode word
      chk("R2 mask cleared", mask, 0);
      chk("R2 spec cleared", spec_mask, 0);
      chk("R2 slave cleared", slave_cfg, 0);
      chk("R4 mode cleared", modev(), 0);
      wr(1'b1, 8'h08);
      chk("R3 vec second", vec_base, 8'h08);
      chk("R3 done skip both", init_done, 1);
      chk("R4 mode still zero", modev(), 0);
      wr(1'b1, 8'h3C);
      chk("R7 mask load2", mask, 8'h3C);
   endtask

   task automatic t_buf_rules();
      wr(1'b0, 8'h13);
      wr(1'b1, 8'h20);
      chk("R3 no cascade step", init_done, 0);
      wr(1'b1, 8'h0B);                       // BUF=1 M/S=0
      chk("R5 buffered slave", {buf_mode, buf_master, aeoi, cpu86}, 4'b1011);
      wr(1'b0, 8'h13);
      wr(1'b1, 8'h20);
      wr(1'b1, 8'h04);                       // BUF=0 M/S=1
      chk("R5 ms ignored", {buf_mode, buf_master}, 2'b00);
      wr(1'b0, 8'h13);
      wr(1'b1, 8'h20);
      wr(1'b1, 8'h0C);
      chk("R5 buffered master", {buf_mode, buf_master}, 2'b11);
   endtask

   task automatic t_restart_mid();
      wr(1'b0, 8'h11);                       // cascade + mode word
      wr(1'b1, 8'h80);
      wr(1'b0, 8'h10);                       // restart before cascade word
      chk("R2 restart mid", init_done, 0);
      wr(1'b1, 8'hC8);
      chk("R2 next hi write is vec", vec_base, 8'hC8);
      chk("R2 slave untouched", slave_cfg, 0);
      wr(1'b1, 8'h07);
      chk("R3 slave after restart", slave_cfg, 8'h07);
      chk("R3 done no mode word", init_done, 1);
   endtask

   task automatic t_ocw2();
      wr(1'b0, 8'hE5);
      chk("R8 strobe", ocw2_stb, 1);
      chk("R8 fields", {rot, sel, eoi, lvl}, 6'b111101);
      chk("R11 other strobes", {ocw3_stb, init_clr}, 0);
      idle();
      chk("R8 one cycle", ocw2_stb, 0);
      chk("R8 held", {rot, sel, eoi, lvl}, 6'b111101);
      wr(1'b0, 8'h22);
      chk("R8 fields2", {rot, sel, eoi, lvl}, 6'b001010);
      chk("R7 mask kept", mask, 0);
   endtask

   task automatic t_ocw3();
      wr(1'b0, 8'h6F);
      chk("R9 strobe", ocw3_stb, 1);
      chk("R9 fields", {poll, rd_reg, rd_is}, 3'b111);
      chk("R10 enter", spec_mask, 1);
      chk("R11 no ocw2", ocw2_stb, 0);
      idle();
      chk("R9 one cycle", ocw3_stb, 0);
      wr(1'b0, 8'h28);                       // SMM without enable
      chk("R10 ignored", spec_mask, 1);
      chk("R9 fields cleared", {poll, rd_reg, rd_is}, 0);
      wr(1'b0, 8'h48);
      chk("R10 leave", spec_mask, 0);
      wr(1'b0, 8'h68);
      wr(1'b0, 8'h10);
      chk("R2 spec cleared run", spec_mask, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      idle();
      t_reset();
      t_full_seq();
      t_skip_mode();
      t_buf_rules();
      t_restart_mid();
      t_ocw2();
      t_ocw3();
      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!finished) begin
         finished = 1'b1;
         n_bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule